// File: doc/BRIEF.md
# Reduced Rijndael cipher core

This block encrypts a 32-bit plaintext under a 32-bit key with a scaled-down Rijndael cipher. The data is held as a 2x2 matrix of bytes; each column is a 16-bit word, and the round key has two such words. Operands reach the core through a 16-bit chunk port. An internal counter steps through four slots in a fixed order: text upper half, text lower half, key upper half, key lower half. When a start pulse arrives while the core is idle, it copies the loaded operands, adds the key, and then runs ten rounds. Each round does byte substitution, a row swap, column mixing and round-key addition. The last round leaves out the mixing step. At the end the core raises a one-cycle done flag, and the ciphertext is then on the output.

Round keys are expanded on the fly, one per round, interleaved with the data rounds. Only two S-box instances exist. The key schedule and the data path take turns on them, so one round takes three clock cycles: key step, substitution of column 0, then substitution of column 1 together with the rest of the round.

Top module: `rjr_core`

## Requirements
- R1: After reset, `done` is 0 and `cipher` is 0.
- R2: Each cycle with `ld_we` high writes `ld_data` into the next slot. The slots are, in order: text[31:16], text[15:0], key[31:16], key[15:0]. After the fourth slot the counter wraps to the first, so a fifth write replaces text[31:16] only.
- R3: The ciphertext equals the following sequence. First, state = text XOR key. Then ten rounds of SubBytes, ShiftRows, MixColumns and AddRoundKey. MixColumns is skipped in round 10. Byte layout: state[31:24]=row0/col0, [23:16]=row1/col0, [15:8]=row0/col1, [7:0]=row1/col1.
- R4: Byte substitution is the standard Rijndael S-box: the multiplicative inverse in GF(2^8) modulo 0x11B, followed by the affine map with constant 0x63. For example S(0x00)=0x63, S(0x01)=0x7C, S(0x53)=0xED.
- R5: ShiftRows keeps row 0 and swaps the two bytes of row 1. MixColumns maps each column (a,b) to (3a^2b, 2a^3b) over GF(2^8) with polynomial 0x11B.
- R6: The round-key words are built as follows, with w0 = key[31:16] and w1 = key[15:0]. The new w0 is the old w0 XOR S-box(byte-rotated old w1) XOR {0x00, rc}. The new w1 is the old w1 XOR the new w0. rc is 0x02 in round 1 and is doubled in GF(2^8) for each later round.
- R7: `done` is high for exactly one cycle. It rises 30 clock edges after the edge that accepts `start`, which is 3 cycles per round.
- R8: `cipher` changes only together with a `done` pulse and otherwise holds its value.
- R9: A `start` received while a run is in progress is ignored. The run keeps its timing and its result.
- R10: Chunk writes during a run do not affect that run. The new operands are used from the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Write strobe for one operand chunk |
| ld_data | input | 16 | Operand chunk data |
| start | input | 1 | Begin encryption when idle |
| done | output | 1 | One-cycle pulse: ciphertext valid |
| cipher | output | 32 | Ciphertext, held between runs |

## Verification
On every cycle, the assertions check four things: the single-cycle shape of `done`, the exact 30-cycle gap between an accepted start and `done`, that `cipher` holds between pulses, and that the round index stays in range and never falls back while a run is active, so a start during a run cannot restart it. The correctness of the ciphertext itself can only be shown by the bench scenarios. This covers the S-box, the row swap, the mixing matrix and the round-constant sequence. The bench compares the output against its own model for directed and random operands. It also covers the chunk ordering and counter wrap, and operand reloads made during a run.

// File: rtl/rjr_pkg.sv
`timescale 1ns/1ps
package rjr_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int BLK_W    = 2 * WORD_W;
    localparam int NUM_SBOX = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_KEY  = 2'd1,
        PH_SUB0 = 2'd2,
        PH_SUB1 = 2'd3
    } phase_e;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // a^254 is the inverse for a != 0 and gives 0 for a == 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] pw;
        logic [7:0] acc;
        pw  = gf_mul(a, a);
        acc = pw;
        for (int i = 0; i < 6; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        logic [15:0] dbl;
        dbl = {v, v} << n;
        return dbl[15:8];
    endfunction

    function automatic logic [7:0] sbox_affine(input logic [7:0] x);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/rjr_sbox.sv
`timescale 1ns/1ps
module rjr_sbox
    import rjr_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] y
);

    logic [BYTE_W-1:0] inv_w;

    always_comb begin
        inv_w = gf_inv(a);
        y     = sbox_affine(inv_w);
    end

endmodule

// File: rtl/rjr_loader.sv
`timescale 1ns/1ps
module rjr_loader #(
    parameter int BLK_W   = 32,
    parameter int CHUNK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CHUNK_W-1:0] data,
    output logic [BLK_W-1:0]   text,
    output logic [BLK_W-1:0]   key
);

    localparam int TOT    = 2 * BLK_W;
    localparam int NCHUNK = TOT / CHUNK_W;
    localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    typedef struct packed {
        logic [CW-1:0]  idx;
        logic [TOT-1:0] opnd;
    } ld_s;

    ld_s ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (we) begin
            for (int i = 0; i < NCHUNK; i++) begin
                if (ld_q.idx == CW'(i)) begin
                    ld_d.opnd[TOT-1-i*CHUNK_W -: CHUNK_W] = data;
                end
            end
            ld_d.idx = (ld_q.idx == CW'(NCHUNK - 1)) ? '0 : ld_q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign text = ld_q.opnd[TOT-1 -: BLK_W];
    assign key  = ld_q.opnd[BLK_W-1:0];

endmodule

// File: rtl/rjr_keystep.sv
`timescale 1ns/1ps
module rjr_keystep
    import rjr_pkg::*;
(
    input  logic [BLK_W-1:0]  prev,
    input  logic [WORD_W-1:0] subrot,
    input  logic [BYTE_W-1:0] rc,
    output logic [BLK_W-1:0]  next
);

    logic [WORD_W-1:0] w0_n;
    logic [WORD_W-1:0] w1_n;

    always_comb begin
        w0_n = prev[BLK_W-1 -: WORD_W] ^ subrot ^ {{BYTE_W{1'b0}}, rc};
        w1_n = prev[WORD_W-1:0] ^ w0_n;
        next = {w0_n, w1_n};
    end

endmodule

// File: rtl/rjr_mixer.sv
`timescale 1ns/1ps
module rjr_mixer
    import rjr_pkg::*;
(
    input  logic [WORD_W-1:0] sw0,
    input  logic [WORD_W-1:0] sw1,
    input  logic [BLK_W-1:0]  rkey,
    input  logic              last,
    output logic [BLK_W-1:0]  result
);

    logic [BYTE_W-1:0] c0a, c0b, c1a, c1b;
    logic [BYTE_W-1:0] m0a, m0b, m1a, m1b;
    logic [BLK_W-1:0]  pre;

    always_comb begin
        // row 0 stays, row 1 bytes trade columns
        c0a = sw0[15:8];
        c0b = sw1[7:0];
        c1a = sw1[15:8];
        c1b = sw0[7:0];
        // (a,b) -> (3a^2b, 2a^3b)
        m0a = gf_dbl(c0a) ^ c0a ^ gf_dbl(c0b);
        m0b = gf_dbl(c0a) ^ gf_dbl(c0b) ^ c0b;
        m1a = gf_dbl(c1a) ^ c1a ^ gf_dbl(c1b);
        m1b = gf_dbl(c1a) ^ gf_dbl(c1b) ^ c1b;
        if (last) pre = {c0a, c0b, c1a, c1b};
        else      pre = {m0a, m0b, m1a, m1b};
        result = pre ^ rkey;
    end

endmodule

// File: rtl/rjr_core.sv
`timescale 1ns/1ps
module rjr_core
    import rjr_pkg::*;
#(
    parameter int          NUM_ROUNDS = 10,
    parameter int          CHUNK_W    = 16,
    parameter logic [7:0]  RC_FIRST   = 8'h02
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [CHUNK_W-1:0] ld_data,
    input  logic               start,
    output logic               done,
    output logic [BLK_W-1:0]   cipher
);

    localparam int RW = $clog2(NUM_ROUNDS + 1);

    typedef struct packed {
        phase_e            phase;
        logic [RW-1:0]     round;
        logic [BYTE_W-1:0] rc;
        logic [BLK_W-1:0]  state;
        logic [BLK_W-1:0]  rkey;
        logic [WORD_W-1:0] sub0;
        logic              done;
        logic [BLK_W-1:0]  cipher;
    } core_s;

    core_s r_d, r_q;

    logic [BLK_W-1:0] text_w, key_w;
    logic [NUM_SBOX-1:0][BYTE_W-1:0] sb_in, sb_out;
    logic [WORD_W-1:0] sub_pair;
    logic [BLK_W-1:0]  key_nxt;
    logic [BLK_W-1:0]  round_out;
    logic              last_round;
    logic              busy;
    logic [RW-1:0]     round_now;

    rjr_loader #(
        .BLK_W   (BLK_W),
        .CHUNK_W (CHUNK_W)
    ) u_loader (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we),
        .data  (ld_data),
        .text  (text_w),
        .key   (key_w)
    );

    // the two substitution units are time-shared by phase
    always_comb begin
        sb_in = '0;
        case (r_q.phase)
            PH_KEY: begin
                sb_in[0] = r_q.rkey[7:0];
                sb_in[1] = r_q.rkey[15:8];
            end
            PH_SUB0: begin
                sb_in[0] = r_q.state[31:24];
                sb_in[1] = r_q.state[23:16];
            end
            PH_SUB1: begin
                sb_in[0] = r_q.state[15:8];
                sb_in[1] = r_q.state[7:0];
            end
            default: sb_in = '0;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_SBOX; g++) begin : g_sbox
            rjr_sbox u_sbox (
                .a (sb_in[g]),
                .y (sb_out[g])
            );
        end
    endgenerate

    assign sub_pair   = {sb_out[0], sb_out[1]};
    assign last_round = (r_q.round == RW'(NUM_ROUNDS));

    rjr_keystep u_keystep (
        .prev   (r_q.rkey),
        .subrot (sub_pair),
        .rc     (r_q.rc),
        .next   (key_nxt)
    );

    rjr_mixer u_mixer (
        .sw0    (r_q.sub0),
        .sw1    (sub_pair),
        .rkey   (r_q.rkey),
        .last   (last_round),
        .result (round_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.phase = PH_KEY;
                    r_d.round = RW'(1);
                    r_d.rc    = RC_FIRST;
                    r_d.state = text_w ^ key_w;
                    r_d.rkey  = key_w;
                end
            end
            PH_KEY: begin
                r_d.rkey  = key_nxt;
                r_d.rc    = gf_dbl(r_q.rc);
                r_d.phase = PH_SUB0;
            end
            PH_SUB0: begin
                r_d.sub0  = sub_pair;
                r_d.phase = PH_SUB1;
            end
            PH_SUB1: begin
                r_d.state = round_out;
                if (last_round) begin
                    r_d.phase  = PH_IDLE;
                    r_d.done   = 1'b1;
                    r_d.cipher = round_out;
                end else begin
                    r_d.round = r_q.round + RW'(1);
                    r_d.phase = PH_KEY;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done      = r_q.done;
    assign cipher    = r_q.cipher;
    assign busy      = (r_q.phase != PH_IDLE);
    assign round_now = r_q.round;

endmodule

// File: rtl/rjr_core_chk.sv
`timescale 1ns/1ps
module rjr_core_chk #(
    parameter int NUM_ROUNDS = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              start,
    input logic                              done,
    input logic [31:0]                       cipher,
    input logic                              busy,
    input logic [$clog2(NUM_ROUNDS+1)-1:0]   round
);

    localparam int RW   = $clog2(NUM_ROUNDS + 1);
    localparam int LAT  = 3 * NUM_ROUNDS;
    localparam int CNTW = $clog2(LAT + 2);

    logic            run_q;
    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!busy && start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + CNTW'(1);
            if (done) run_q <= 1'b0;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q && cnt_q == CNTW'(LAT)));

    assert_cipher_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cipher));

    assert_round_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (round >= RW'(1) && round <= RW'(NUM_ROUNDS)));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (round >= $past(round)));

endmodule

bind rjr_core rjr_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .cipher (cipher),
    .busy   (busy),
    .round  (round_now)
);

// File: tb/tb_rjr_core.sv
`timescale 1ns/1ps
module tb_rjr_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_we;
    logic [15:0] ld_data;
    logic        start;
    logic        done;
    logic [31:0] cipher;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0] sbt [256];

    always #2.5 clk = ~clk;

    rjr_core dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_we),
        .ld_data (ld_data),
        .start   (start),
        .done    (done),
        .cipher  (cipher)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_x2(input logic [7:0] a);
        logic [7:0] r;
        r = a << 1;
        if (a[7]) r = r ^ 8'h1b;
        return r;
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        while (bb != 0) begin
            if (bb[0]) p = p ^ aa;
            aa = m_x2(aa);
            bb = bb >> 1;
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int b = 1; b < 256; b++)
                if (a != 0 && m_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
            sbt[a] = s ^ 8'h63;
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] pt, input logic [31:0] k);
        logic [7:0] st [4];
        logic [7:0] kb [4];
        logic [7:0] rc = 8'h02;
        logic [7:0] t0, t1, a0, b0, a1, b1;
        for (int i = 0; i < 4; i++) begin
            kb[i] = k[31-8*i -: 8];
            st[i] = pt[31-8*i -: 8] ^ kb[i];
        end
        for (int r = 1; r <= 10; r++) begin
            t0 = sbt[kb[3]];
            t1 = sbt[kb[2]];
            kb[0] = kb[0] ^ t0;
            kb[1] = kb[1] ^ t1 ^ rc;
            kb[2] = kb[2] ^ kb[0];
            kb[3] = kb[3] ^ kb[1];
            rc = m_x2(rc);
            a0 = sbt[st[0]]; b0 = sbt[st[3]];
            a1 = sbt[st[2]]; b1 = sbt[st[1]];
            if (r < 10) begin
                st[0] = m_mul(8'h03, a0) ^ m_mul(8'h02, b0);
                st[1] = m_mul(8'h02, a0) ^ m_mul(8'h03, b0);
                st[2] = m_mul(8'h03, a1) ^ m_mul(8'h02, b1);
                st[3] = m_mul(8'h02, a1) ^ m_mul(8'h03, b1);
            end else begin
                st[0] = a0; st[1] = b0; st[2] = a1; st[3] = b1;
            end
            for (int i = 0; i < 4; i++) st[i] = st[i] ^ kb[i];
        end
        return {st[0], st[1], st[2], st[3]};
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic put_chunk(input logic [15:0] d);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_data = d;
        @(posedge clk);
        #1 ld_we = 1'b0;
    endtask

    task automatic load_all(input logic [31:0] t, input logic [31:0] k);
        put_chunk(t[31:16]);
        put_chunk(t[15:0]);
        put_chunk(k[31:16]);
        put_chunk(k[15:0]);
    endtask

    // mode 0: plain, 1: extra start mid-run, 2: reload operands mid-run
    task automatic run_enc(input int mode, input logic [63:0] nxt,
                           output int lat, output int nd, output logic [31:0] got);
        lat = -1;
        nd  = 0;
        got = 32'h0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin
                nd++;
                if (lat < 0) begin
                    lat = k;
                    got = cipher;
                end
            end
            if (mode == 1) start = (k == 10);
            if (mode == 2) begin
                if (k >= 5 && k <= 8) begin
                    ld_we   = 1'b1;
                    ld_data = nxt[63-16*(k-5) -: 16];
                end else begin
                    ld_we = 1'b0;
                end
            end
        end
        start = 1'b0;
        ld_we = 1'b0;
    endtask

    task automatic enc_check(input string tag, input logic [31:0] t, input logic [31:0] k);
        int lat, nd;
        logic [31:0] got;
        load_all(t, k);
        run_enc(0, 64'h0, lat, nd, got);
        chk({tag, " cipher"}, got, model(t, k));
        chk("R7 latency", 32'(lat), 32'd30);
        chk("R7 single pulse", 32'(nd), 32'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(150000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        int lat, nd;
        logic [31:0] got, got2, t, k;
        void'($urandom(32'd7351));
        rst_n   = 1'b0;
        ld_we   = 1'b0;
        ld_data = 16'h0;
        start   = 1'b0;
        build_sbox();
        repeat (3) @(negedge clk);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 cipher at reset", cipher, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);

        // bench table sanity for R4 values
        chk("R4 table S(00)", 32'(sbt[8'h00]), 32'h63);
        chk("R4 table S(01)", 32'(sbt[8'h01]), 32'h7c);
        chk("R4 table S(53)", 32'(sbt[8'h53]), 32'hed);

        // directed corner cases
        enc_check("R4 zero text zero key", 32'h0, 32'h0);
        enc_check("R6 ones key", 32'h0, 32'hffff_ffff);
        enc_check("R5 row1 pattern", 32'h00ff_00a5, 32'h0000_0000);
        enc_check("R3 mixed pattern", 32'h0123_4567, 32'h89ab_cdef);

        // random operands
        for (int i = 0; i < 16; i++) begin
            t = $urandom();
            k = $urandom();
            enc_check("R3 random", t, k);
        end

        // R8: ciphertext held after the pulse
        t = 32'hdead_beef; k = 32'h1357_9bdf;
        load_all(t, k);
        run_enc(0, 64'h0, lat, nd, got);
        repeat (20) @(negedge clk);
        chk("R8 cipher held", cipher, got);
        chk("R8 done stays low", 32'(done), 32'd0);

        // R9: start during a run is ignored
        t = 32'hcafe_0042; k = 32'h0bad_f00d;
        load_all(t, k);
        run_enc(1, 64'h0, lat, nd, got);
        chk("R9 cipher", got, model(t, k));
        chk("R9 latency", 32'(lat), 32'd30);
        chk("R9 one done only", 32'(nd), 32'd1);

        // R10: reload during a run
        t = 32'h1111_2222; k = 32'h3333_4444;
        load_all(t, k);
        run_enc(2, {32'h5555_6666, 32'h7777_8888}, lat, nd, got);
        chk("R10 run unaffected", got, model(t, k));
        run_enc(0, 64'h0, lat, nd, got2);
        chk("R10 new operands used", got2, model(32'h5555_6666, 32'h7777_8888));

        // R2: counter wrap, fifth write replaces text upper half only
        t = 32'habcd_0123; k = 32'h4567_89ab;
        load_all(t, k);
        put_chunk(16'h9e37);
        run_enc(0, 64'h0, lat, nd, got);
        chk("R2 wrap to first slot", got, model({16'h9e37, 16'h0123}, k));
        put_chunk(16'h5a5a);
        put_chunk(16'hc3c3);
        put_chunk(16'h0ff0);
        run_enc(0, 64'h0, lat, nd, got);
        chk("R2 slot order after wrap", got, model({16'h9e37, 16'h5a5a}, {16'hc3c3, 16'h0ff0}));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule